// File: doc/BRIEF.md
# GPIO Pad Control Register Bank

This block holds the byte-wide control registers of thirteen general-purpose pins and turns them into pad controls. Each pin owns two registers. The output-control register sets the pin's direction, its drive type (push-pull or open-drain), its pull-resistor enable and a two-bit pull code, and it holds the value the pin drives. The input-control register returns the pin's synchronized level and stores a two-bit interrupt edge code. The edge code is not used inside the block; it is passed on to the interrupt logic next to it.

Software reaches the registers over a simple synchronous bus. A write carries a per-bit mask, so the driven value can be changed without touching the pin's configuration. Read data is registered and appears in the cycle after the read strobe. Pad inputs pass through a two-flop synchronizer before they show in the input-control register. In open-drain mode the pad is only ever pulled low; a driven 1 releases the pad.

Top module: `pad_ctl_bank`

## Requirements
- R1: After reset, every output-control register reads 0x00, every edge code is 00, and pad_oe, pad_out, pull_en, pull_sel and edge_mode are all zero.
- R2: The output-control register of pin k (k = 0..12) is at address 0x4E44+k, and its input-control register is at 0x4E51+k. A read strobe in one cycle returns the addressed byte on bus_rdata in the next cycle. bus_rdata is 0x00 in any cycle that does not follow a read strobe.
- R3: In the output-control register, bit 5 is direction (1 = output), bit 4 is drive type (1 = push-pull, 0 = open-drain), bit 3 is pull enable, bits 2:1 are the pull code and bit 0 is the driven value. Bits 7:6 read as 0. pull_en[k] follows bit 3 of pin k, and pull_sel[2k+1:2k] follows bits 2:1, from the cycle after the write.
- R4: In push-pull mode, pad_oe[k] equals the direction bit and pad_out[k] equals bit 0.
- R5: In open-drain mode, pad_oe[k] is 1 only when the direction bit is 1 and bit 0 is 0. While the pad is enabled in this mode it is driven low.
- R6: A write changes only the register bits whose bus_wmask bit is 1. A write with mask 0x01 to an output-control register changes only the driven value.
- R7: Bit 0 of the input-control register shows pad_in[k] after two clock edges of synchronization. A read issued in the cycle right after pad_in changes still returns the old level.
- R8: Bits 2:1 of the input-control register hold an edge code that can be read and written, and edge_mode[2k+1:2k] follows it. Writes to bit 0 and bits 7:3 of this register are ignored, and bits 7:3 read as 0.
- R9: Reads from addresses outside both register ranges return 0x00. Writes to them change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wmask | input | 8 | Per-bit write enable mask |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, valid the cycle after bus_re |
| pad_in | input | 13 | Raw pad levels |
| pad_out | output | 13 | Pad output values |
| pad_oe | output | 13 | Pad output enables |
| pull_en | output | 13 | Pull-resistor enables |
| pull_sel | output | 26 | Pull codes, two bits per pin |
| edge_mode | output | 26 | Edge codes, two bits per pin |

## Verification
A vector table writes full and masked bytes to the first pin, the last pin and a middle pin of both register ranges, and then reads each one back. This separates address-decode errors from field-masking errors, and shows whether the read-only and reserved bits are kept out. Directed tests cover all four direction and drive combinations with both driven values, so a push-pull equation used in open-drain mode, or the reverse, gives a different pad_oe. A level change followed by two back-to-back reads shows whether the synchronizer has exactly two stages. Writes to unmapped addresses are followed by a comparison against a snapshot of all outputs.

// File: rtl/pad_ctl_pkg.sv
package pad_ctl_pkg;

    localparam int BYTE_W = 8;
    localparam int CFG_W  = 6;

    // Bit layout of the output-control byte, bit 5 down to bit 0
    typedef struct packed {
        logic       dir;       // 1 = output
        logic       push_pull; // 1 = push-pull, 0 = open-drain
        logic       pull_on;
        logic [1:0] pull_code;
        logic       value;
    } out_cfg_t;

    typedef struct packed {
        out_cfg_t   cfg;
        logic [1:0] edge_code;
    } pin_state_t;

endpackage

// File: rtl/pad_sync.sv
module pad_sync #(
    parameter int W      = 13,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] chain;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.chain[0] = d_in;
        for (int i = 1; i < STAGES; i++) begin
            s_d.chain[i] = s_q.chain[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign d_out = s_q.chain[STAGES-1];

    // checker: count the edges since reset so that $past never reaches into reset
    logic [1:0] age_q;
    always_ff @(posedge clk) begin
        if (!rst_n)               age_q <= '0;
        else if (age_q != 2'd3)   age_q <= age_q + 2'd1;
    end

    generate
        if (STAGES == 2) begin : g_lat_chk
            // R7
            sync_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (age_q >= 2'd2) |-> (d_out == $past(d_in, 2)));
        end
    endgenerate
endmodule

// File: rtl/pad_bus_dec.sv
module pad_bus_dec #(
    parameter int          NUM_PINS = 13,
    parameter logic [15:0] OUT_BASE = 16'h4E44,
    parameter int          IDX_W    = 4
) (
    input  logic [15:0]      addr,
    output logic             out_hit,
    output logic             in_hit,
    output logic [IDX_W-1:0] idx
);
    localparam logic [15:0] IN_BASE = OUT_BASE + 16'(NUM_PINS);
    localparam logic [15:0] N16     = 16'(NUM_PINS);

    logic [15:0] out_off, in_off;

    always_comb begin
        out_off = addr - OUT_BASE;
        in_off  = addr - IN_BASE;
        out_hit = (addr >= OUT_BASE) && (out_off < N16);
        in_hit  = (addr >= IN_BASE)  && (in_off  < N16);
        idx     = in_hit ? in_off[IDX_W-1:0] : out_off[IDX_W-1:0];
    end
endmodule

// File: rtl/pad_pin_ctl.sv
module pad_pin_ctl
    import pad_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       out_wr,
    input  logic       in_wr,
    input  logic [7:0] wdata,
    input  logic [7:0] wmask,
    input  logic       level,
    output logic [7:0] out_rd,
    output logic [7:0] in_rd,
    output logic       pad_out,
    output logic       pad_oe,
    output logic       pull_en,
    output logic [1:0] pull_sel,
    output logic [1:0] edge_mode
);
    pin_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (out_wr) begin
            st_d.cfg = out_cfg_t'((st_q.cfg & ~wmask[CFG_W-1:0]) |
                                  (wdata[CFG_W-1:0] & wmask[CFG_W-1:0]));
        end
        if (in_wr) begin
            st_d.edge_code = (st_q.edge_code & ~wmask[2:1]) | (wdata[2:1] & wmask[2:1]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_rd    = {2'b00, st_q.cfg};
    assign in_rd     = {5'b0, st_q.edge_code, level};
    assign pad_out   = st_q.cfg.value;
    assign pad_oe    = st_q.cfg.dir & (st_q.cfg.push_pull | ~st_q.cfg.value);
    assign pull_en   = st_q.cfg.pull_on;
    assign pull_sel  = st_q.cfg.pull_code;
    assign edge_mode = st_q.edge_code;

    // R6
    mask_bit0_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_wr && wmask == 8'h01) |=> $stable(out_rd[7:1]));

    // R5
    od_drive_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe && !out_rd[4]) |-> !pad_out);

    // R8
    in_wr_no_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_wr && !out_wr) |=> $stable(out_rd));
endmodule

// File: rtl/pad_ctl_bank.sv
module pad_ctl_bank #(
    parameter int          NUM_PINS = 13,
    parameter logic [15:0] OUT_BASE = 16'h4E44,
    parameter int          SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [15:0]           bus_addr,
    input  logic [7:0]            bus_wdata,
    input  logic [7:0]            bus_wmask,
    input  logic                  bus_we,
    input  logic                  bus_re,
    output logic [7:0]            bus_rdata,
    input  logic [NUM_PINS-1:0]   pad_in,
    output logic [NUM_PINS-1:0]   pad_out,
    output logic [NUM_PINS-1:0]   pad_oe,
    output logic [NUM_PINS-1:0]   pull_en,
    output logic [2*NUM_PINS-1:0] pull_sel,
    output logic [2*NUM_PINS-1:0] edge_mode
);
    localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

    logic             out_hit, in_hit;
    logic [IDX_W-1:0] idx;
    logic [NUM_PINS-1:0] level;
    logic [7:0] out_rd [NUM_PINS];
    logic [7:0] in_rd  [NUM_PINS];

    pad_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (pad_in),
        .d_out (level)
    );

    pad_bus_dec #(.NUM_PINS(NUM_PINS), .OUT_BASE(OUT_BASE), .IDX_W(IDX_W)) u_dec (
        .addr    (bus_addr),
        .out_hit (out_hit),
        .in_hit  (in_hit),
        .idx     (idx)
    );

    generate
        for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
            logic wr_out, wr_in;
            assign wr_out = bus_we && out_hit && (idx == IDX_W'(k));
            assign wr_in  = bus_we && in_hit  && (idx == IDX_W'(k));

            pad_pin_ctl u_pin (
                .clk       (clk),
                .rst_n     (rst_n),
                .out_wr    (wr_out),
                .in_wr     (wr_in),
                .wdata     (bus_wdata),
                .wmask     (bus_wmask),
                .level     (level[k]),
                .out_rd    (out_rd[k]),
                .in_rd     (in_rd[k]),
                .pad_out   (pad_out[k]),
                .pad_oe    (pad_oe[k]),
                .pull_en   (pull_en[k]),
                .pull_sel  (pull_sel[2*k+1:2*k]),
                .edge_mode (edge_mode[2*k+1:2*k])
            );
        end
    endgenerate

    typedef struct packed {
        logic [7:0] rdata;
    } rd_state_t;

    rd_state_t r_d, r_q;

    always_comb begin
        r_d = '0;
        if (bus_re) begin
            for (int k = 0; k < NUM_PINS; k++) begin
                if (idx == IDX_W'(k)) begin
                    if (out_hit)     r_d.rdata = out_rd[k];
                    else if (in_hit) r_d.rdata = in_rd[k];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign bus_rdata = r_q.rdata;

    // R9
    unmapped_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && !out_hit && !in_hit) |=> (bus_rdata == 8'h00));

    // R9
    unmapped_wr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !out_hit && !in_hit) |=>
            $stable({pad_out, pad_oe, pull_en, pull_sel, edge_mode}));

    // R2
    idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> (bus_rdata == 8'h00));

    // R2
    single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_hit && in_hit));
endmodule

// File: tb/tb_pad_ctl_bank.sv
module tb_pad_ctl_bank;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 13;

    logic clk = 1'b0;
    logic rst_n;
    logic [15:0] bus_addr;
    logic [7:0]  bus_wdata, bus_wmask, bus_rdata;
    logic        bus_we, bus_re;
    logic [NP-1:0]   pad_in, pad_out, pad_oe, pull_en;
    logic [2*NP-1:0] pull_sel, edge_mode;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pad_ctl_bank dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wmask(bus_wmask), .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pull_en(pull_en),
        .pull_sel(pull_sel), .edge_mode(edge_mode)
    );

    typedef struct packed {
        logic [15:0] addr;
        logic [7:0]  wdata;
        logic [7:0]  mask;
        logic [7:0]  exp;
    } vec_t;

    // write, then read back and expect exp (pad_in held at 0)
    localparam vec_t VECS [12] = '{
        '{16'h4E44, 8'hFF, 8'hFF, 8'h3F}, // R3 pin0, bits 7:6 read 0
        '{16'h4E44, 8'h00, 8'h01, 8'h3E}, // R6 only value bit cleared
        '{16'h4E50, 8'h2A, 8'hFF, 8'h2A}, // R2 last pin
        '{16'h4E50, 8'h01, 8'h01, 8'h2B}, // R6
        '{16'h4E50, 8'h00, 8'h20, 8'h0B}, // R6 direction only
        '{16'h4E5D, 8'hFF, 8'hFF, 8'h06}, // R8 bit0 and 7:3 ignored
        '{16'h4E58, 8'h04, 8'hFF, 8'h04}, // R8 pin7
        '{16'h4E58, 8'h02, 8'h02, 8'h06}, // R6 R8 masked edge bit
        '{16'h4E51, 8'h02, 8'hFF, 8'h02}, // R2 first input register
        '{16'h4E4B, 8'h35, 8'hFF, 8'h35}, // R2 pin7 output register
        '{16'h4E5E, 8'hFF, 8'hFF, 8'h00}, // R9 past the end
        '{16'h4E43, 8'hFF, 8'hFF, 8'h00}  // R9 before the start
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic [7:0] m);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wmask = m; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        v = bus_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [5*NP+4*NP-1:0] snap;
        rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_wmask = '0;
        bus_we = 1'b0; bus_re = 1'b0; pad_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 pad_oe", 32'(pad_oe), 32'h0);
        chk("R1 pad_out", 32'(pad_out), 32'h0);
        chk("R1 pull_en", 32'(pull_en), 32'h0);
        chk("R1 pull_sel", 32'(pull_sel), 32'h0);
        chk("R1 edge_mode", 32'(edge_mode), 32'h0);
        rd(16'h4E49, v); chk("R1 out reg pin5", 32'(v), 32'h0);
        chk("R2 idle rdata", 32'(bus_rdata), 32'h0);

        // table walk
        for (int i = 0; i < 12; i++) begin
            wr(VECS[i].addr, VECS[i].wdata, VECS[i].mask);
            rd(VECS[i].addr, v);
            chk($sformatf("R2/R3/R6/R8/R9 vec %0d", i), 32'(v), 32'(VECS[i].exp));
        end

        // R3 decoded outputs after the table
        chk("R3 pull_en", 32'(pull_en), 32'h1001);
        chk("R3 pull_sel pin0", 32'(pull_sel[1:0]), 32'h3);
        chk("R3 pull_sel pin12", 32'(pull_sel[25:24]), 32'h1);
        chk("R3 pull_sel pin7", 32'(pull_sel[15:14]), 32'h2);
        chk("R8 edge pin0", 32'(edge_mode[1:0]), 32'h1);
        chk("R8 edge pin7", 32'(edge_mode[15:14]), 32'h3);
        chk("R8 edge pin12", 32'(edge_mode[25:24]), 32'h3);
        chk("R4 pin0 oe", 32'(pad_oe[0]), 32'h1);
        chk("R4 pin7 out", 32'(pad_out[7]), 32'h1);
        chk("R4 pin12 oe (input)", 32'(pad_oe[12]), 32'h0);

        // R5 open-drain, R4 push-pull on pin3
        wr(16'h4E47, 8'h20, 8'hFF);
        chk("R5 od drive 0 oe", 32'(pad_oe[3]), 32'h1);
        chk("R5 od drive 0 out", 32'(pad_out[3]), 32'h0);
        wr(16'h4E47, 8'h01, 8'h01);
        chk("R5 od value 1 released", 32'(pad_oe[3]), 32'h0);
        chk("R6 od value 1 out", 32'(pad_out[3]), 32'h1);
        wr(16'h4E47, 8'h10, 8'h10);
        chk("R4 pp value 1 oe", 32'(pad_oe[3]), 32'h1);
        wr(16'h4E47, 8'h00, 8'h01);
        chk("R4 pp value 0 oe", 32'(pad_oe[3]), 32'h1);
        chk("R4 pp value 0 out", 32'(pad_out[3]), 32'h0);
        wr(16'h4E47, 8'h00, 8'h20);
        chk("R4 pp input oe", 32'(pad_oe[3]), 32'h0);
        wr(16'h4E47, 8'h00, 8'h10);
        chk("R5 od input oe", 32'(pad_oe[3]), 32'h0);

        // R7 two-stage synchronizer on pin4
        @(negedge clk);
        pad_in[4] = 1'b1;
        rd(16'h4E55, v); chk("R7 first read old level", 32'(v), 32'h0);
        rd(16'h4E55, v); chk("R7 second read new level", 32'(v), 32'h1);
        pad_in[4] = 1'b0;
        repeat (3) @(negedge clk);
        rd(16'h4E55, v); chk("R7 level low again", 32'(v), 32'h0);

        // R9 unmapped write leaves every output alone
        snap = {pad_out, pad_oe, pull_en, pull_sel, edge_mode};
        wr(16'h4E60, 8'hFF, 8'hFF);
        wr(16'h0000, 8'hFF, 8'hFF);
        chk("R9 outputs unchanged", 32'({pad_out, pad_oe, pull_en, pull_sel, edge_mode} != snap),
            32'h0);
        rd(16'hFFFF, v); chk("R9 read high address", 32'(v), 32'h0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule